// File: doc/BRIEF.md
# Masked aligned vector move unit

This block carries out one aligned packed-integer vector move on operands of up to 512 bits. The surrounding pipeline supplies the current destination contents (a register value or, for stores, the memory line), the source value and the decoded attributes of the move. These attributes are the encoding class, the vector length, the element width, the writemask with its enable and merge/zero select, the opcode direction, whether an operand lives in memory, the low address bits and the 4-bit vvvv field. The block returns the new destination value, a write strobe and two fault flags.

Masking works per element at 32-bit or 64-bit granularity. Load and register-copy forms can merge or zero the elements that are masked off. Store forms only merge. The bits above the vector length are cleared, kept or left alone according to the encoding class and the direction. An undefined-opcode check on the vvvv field and a general-protection check on operand alignment suppress the write when they fire.

Both edges of the block use valid/ready handshakes. An input is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the single output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output holds steady and no new input is taken.

Top module: `vmove_unit`

## Requirements
- R1: `elem64`=0 selects 32-bit elements and `elem64`=1 selects 64-bit elements. `vlen` codes 0, 1 and 2 mean 128, 256 and 512 bits, which gives 4/8/16 or 2/4/8 active elements. Element j occupies bits j*EW+EW-1 : j*EW of the 512-bit vectors.
- R2: An active element takes the source value when mask bit j is 1, when `mask_en` is 0, or when `enc` is not EVEX. `enc` codes are 0 = legacy, 1 = VEX, 2 = EVEX and 3 = reserved.
- R3: In load and register-copy forms, a masked-off active element keeps its old value when `zero_mode`=0 and becomes zero when `zero_mode`=1.
- R4: A store form (`dir_from_reg`=1, the 7F direction, together with `mem_op`=1) keeps every masked-off element old, whatever `zero_mode` says. With `dir_from_reg`=1 and `mem_op`=0 the move is a register copy and follows R3 and R5.
- R5: VEX and EVEX load and register-copy forms clear every destination bit from the vector length up to bit 511.
- R6: The legacy class always moves 128 bits, whatever `vlen` says, and leaves bits 511:128 unchanged. No store form changes any bit above the vector length.
- R7: When `mem_op`=1, the move raises `fault_gp` if `addr_lo` is not a multiple of 16, 32 or 64 for a vector length of 128, 256 or 512 bits.
- R8: `fault_ud` is raised for VEX and EVEX moves whose `vvvv` differs from 4'b1111 or whose `vlen` is 3, and for `enc`=3. The legacy class ignores `vvvv`.
- R9: On any fault, `wr_en` is 0 and `new_dst` equals the old value. `fault_ud` takes priority, so `fault_gp` is never high together with it.
- R10: Only the low KL bits of `wmask` are used. KL is the active element count, and the bits above it have no effect.
- R11: A result appears on the outputs with `out_valid` one clock after the input is accepted. While `out_valid`=1 and `out_ready`=0 the outputs stay stable and `in_ready` is 0.
- R12: An active-low synchronous reset clears `out_valid`, `wr_en`, both faults and `new_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input move descriptor valid |
| in_ready | output | 1 | Block can accept a move |
| old_dst | input | 512 | Current destination contents |
| src | input | 512 | Source operand |
| wmask | input | 16 | Writemask, bit j for element j |
| mask_en | input | 1 | Writemask enabled |
| zero_mode | input | 1 | 1 = zero masking, 0 = merge masking |
| elem64 | input | 1 | Element width select |
| vlen | input | 2 | Vector length code |
| enc | input | 2 | Encoding class code |
| dir_from_reg | input | 1 | 1 = 7F direction, 0 = 6F direction |
| mem_op | input | 1 | An operand is in memory |
| addr_lo | input | 6 | Low address bits of the memory operand |
| vvvv | input | 4 | Reserved register-specifier field |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| new_dst | output | 512 | New destination value |
| wr_en | output | 1 | Destination write strobe |
| fault_ud | output | 1 | Undefined-opcode fault |
| fault_gp | output | 1 | General-protection fault |

## Verification
A lane-select error shows up in the very result that follows the faulty input. The errors are a wrong element granularity, a wrong active-lane bound, or a confusion between store and register-copy. They appear as a single 32-bit word of `new_dst` that holds the old, source or zero value where another was due, often only above bit 127 or only for 64-bit elements. Because of this, the vectors give every dword of old and source a distinct value and vary the class, length and direction. A wrong fault or handshake state shows on the cycle after acceptance as a misplaced `wr_en` or fault flag, or under a stall as an output that changes before it is drained.

// File: rtl/vmove_pkg.sv
package vmove_pkg;
  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX    = 2'd1,
    ENC_EVEX   = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_e;

  localparam int BASE_BITS  = 128;
  localparam int BASE_BYTES = BASE_BITS / 8;
  localparam logic [1:0] VLEN_BAD = 2'd3;
endpackage

// File: rtl/vmove_fault_chk.sv
module vmove_fault_chk
  import vmove_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [1:0]        enc,
  input  logic [1:0]        vlen,
  input  logic [3:0]        vvvv,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] addr_lo,
  output logic [1:0]        eff_vlen,
  output logic              ud,
  output logic              gp
);
  logic [ADDR_W-1:0] align_mask;
  logic              modern;

  // Legacy class is fixed at 128 bits
  assign modern   = (enc == ENC_VEX) || (enc == ENC_EVEX);
  assign eff_vlen = (enc == ENC_LEGACY) ? 2'd0 : vlen;

  always_comb begin
    ud = 1'b0;
    if (enc == ENC_RSVD) ud = 1'b1;
    if (modern && ((vvvv != 4'hF) || (vlen == VLEN_BAD))) ud = 1'b1;
  end

  assign align_mask = ADDR_W'((32'(BASE_BYTES) << eff_vlen) - 32'd1);
  assign gp = !ud && mem_op && (|(addr_lo & align_mask));
endmodule

// File: rtl/vmove_lane_sel.sv
module vmove_lane_sel #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16,
  parameter int MASK_W = 16
) (
  input  logic [LANES*LANE_W-1:0] old_v,
  input  logic [LANES*LANE_W-1:0] src_v,
  input  logic [MASK_W-1:0]       wmask,
  input  logic                    mask_on,
  input  logic                    zero_mode,
  input  logic                    elem64,
  input  logic [1:0]              eff_vlen,
  input  logic                    store_form,
  input  logic                    clear_upper,
  output logic [LANES*LANE_W-1:0] res_v
);
  localparam int AW   = $clog2(LANES) + 2;
  localparam int BASE = 128 / LANE_W;

  logic [AW-1:0] active;
  assign active = AW'(BASE) << eff_vlen;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [AW-1:0] LIDX = AW'(g);
    logic in_range, mbit, take;
    logic [LANE_W-1:0] o_w, s_w;

    assign o_w      = old_v[g*LANE_W +: LANE_W];
    assign s_w      = src_v[g*LANE_W +: LANE_W];
    assign in_range = LIDX < active;
    // A 64-bit element spans two dword lanes sharing one mask bit
    assign mbit     = elem64 ? wmask[g/2] : wmask[g];
    assign take     = !mask_on || mbit;

    always_comb begin
      if (in_range) begin
        if (take)                          res_v[g*LANE_W +: LANE_W] = s_w;
        else if (!store_form && zero_mode) res_v[g*LANE_W +: LANE_W] = '0;
        else                               res_v[g*LANE_W +: LANE_W] = o_w;
      end else begin
        if (clear_upper) res_v[g*LANE_W +: LANE_W] = '0;
        else             res_v[g*LANE_W +: LANE_W] = o_w;
      end
    end
  end
endmodule

// File: rtl/vmove_unit.sv
module vmove_unit
  import vmove_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 32,
  parameter int MASK_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  old_dst,
  input  logic [VEC_W-1:0]  src,
  input  logic [MASK_W-1:0] wmask,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic              elem64,
  input  logic [1:0]        vlen,
  input  logic [1:0]        enc,
  input  logic              dir_from_reg,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [3:0]        vvvv,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  new_dst,
  output logic              wr_en,
  output logic              fault_ud,
  output logic              fault_gp
);
  localparam int LANES = VEC_W / LANE_W;

  logic [1:0]       eff_vlen;
  logic             ud_c, gp_c, store_form, mask_on, clear_upper, accept;
  logic [VEC_W-1:0] merged;

  assign store_form  = dir_from_reg && mem_op;
  assign mask_on     = mask_en && (enc == ENC_EVEX);
  assign clear_upper = (enc != ENC_LEGACY) && !store_form;

  vmove_fault_chk #(.ADDR_W(ADDR_W)) u_fault (
    .enc(enc), .vlen(vlen), .vvvv(vvvv), .mem_op(mem_op), .addr_lo(addr_lo),
    .eff_vlen(eff_vlen), .ud(ud_c), .gp(gp_c)
  );

  vmove_lane_sel #(.LANE_W(LANE_W), .LANES(LANES), .MASK_W(MASK_W)) u_lanes (
    .old_v(old_dst), .src_v(src), .wmask(wmask), .mask_on(mask_on),
    .zero_mode(zero_mode), .elem64(elem64), .eff_vlen(eff_vlen),
    .store_form(store_form), .clear_upper(clear_upper), .res_v(merged)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      new_dst   <= '0;
      wr_en     <= 1'b0;
      fault_ud  <= 1'b0;
      fault_gp  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      new_dst   <= (ud_c || gp_c) ? old_dst : merged;
      wr_en     <= !(ud_c || gp_c);
      fault_ud  <= ud_c;
      fault_gp  <= gp_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      fault_ud  <= 1'b0;
      fault_gp  <= 1'b0;
    end
  end

  a_r11_accept_yields_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(new_dst) && $stable(wr_en)
                                 && $stable(fault_ud) && $stable(fault_gp));
  a_r9_fault_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ud || fault_gp) |-> !wr_en);
  a_r9_ud_over_gp: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_ud && fault_gp));
  a_r11_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);
endmodule

// File: tb/tb_vmove_unit.sv
module tb_vmove_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, wr_en, fault_ud, fault_gp;
  logic [511:0] old_dst = '0, src = '0, new_dst;
  logic [15:0] wmask = '0;
  logic mask_en = 0, zero_mode = 0, elem64 = 0, dir_from_reg = 0, mem_op = 0;
  logic [1:0] vlen = '0, enc = '0;
  logic [5:0] addr_lo = '0;
  logic [3:0] vvvv = 4'hF;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vmove_unit dut (.*);

  // fields: enc, vlen, elem64, mask_en, zero_mode, dir_from_reg, mem_op, addr_lo, vvvv, wmask
  localparam int NV = 18;
  localparam logic [34:0] TBL [NV] = '{
    {2'd2,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,6'h00,4'hF,16'hA5C3}, // R3 merge, R1
    {2'd2,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,6'h00,4'hF,16'h0F0F}, // R3 zero
    {2'd2,2'd1,1'b1,1'b1,1'b1,1'b0,1'b1,6'h20,4'hF,16'hFFF5}, // R10 R5 R1 qwords
    {2'd2,2'd0,1'b0,1'b1,1'b1,1'b1,1'b1,6'h10,4'hF,16'h0006}, // R4 store merges only
    {2'd2,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,6'h00,4'hF,16'h0000}, // R2 mask disabled, R5
    {2'd1,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,6'h00,4'hF,16'h0000}, // R2 VEX ignores mask, R5
    {2'd0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,6'h00,4'h0,16'h0000}, // R6 legacy, R8 vvvv ignored
    {2'd2,2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,6'h00,4'hF,16'h0006}, // R4 7F register copy
    {2'd1,2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,6'h00,4'hF,16'h0000}, // R6 store keeps upper
    {2'd2,2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,6'h20,4'hF,16'hFFFF}, // R7 512 misaligned
    {2'd2,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h08,4'hF,16'hFFFF}, // R7 128 misaligned
    {2'd2,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,6'h30,4'hF,16'hFFFF}, // R7 128 aligned
    {2'd1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'hE,16'h0000}, // R8 bad vvvv
    {2'd2,2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,6'h01,4'h7,16'hFFFF}, // R9 ud over gp
    {2'd3,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'hF,16'h0000}, // R8 reserved class
    {2'd2,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'hF,16'h0000}, // R8 reserved length
    {2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h08,4'hF,16'h0000}, // R7 legacy misaligned
    {2'd2,2'd2,1'b1,1'b1,1'b1,1'b0,1'b0,6'h00,4'hF,16'hFF00}  // R10 high mask bits unused
  };
  localparam int TAG [NV] = '{3,3,10,4,2,2,6,4,6,7,7,7,8,9,8,8,7,10};

  function automatic logic [511:0] pat(input int s);
    logic [511:0] r;
    for (int d = 0; d < 16; d++)
      r[d*32 +: 32] = {8'(s + 1), 8'(d + 1), 8'hC3 ^ 8'(s), 8'(16 * s + d) | 8'h01};
    return r;
  endfunction

  function automatic logic [511:0] model(input logic [34:0] e, input logic [511:0] o,
      input logic [511:0] s, output logic ud, output logic gp, output logic we);
    logic [1:0] ec = e[34:33], vl = e[32:31];
    logic [15:0] k = e[15:0];
    logic [511:0] r = o;
    int bits, ew, kl;
    logic st, on;
    ud = (ec == 2'd3) || (ec != 2'd0 && (e[19:16] != 4'hF || vl == 2'd3));
    bits = (ec == 2'd0 || vl == 2'd3) ? 128 : (128 << vl);
    gp = !ud && e[26] && ((int'(e[25:20]) % (bits / 8)) != 0);
    we = !(ud || gp);
    if (!we) return o;
    st = e[27] && e[26];
    ew = e[30] ? 64 : 32;
    kl = bits / ew;
    for (int j = 0; j < kl; j++) begin
      on = (ec != 2'd2) || !e[29] || k[j];
      for (int b = 0; b < ew; b++)
        if (on) r[j*ew + b] = s[j*ew + b];
        else if (!st && e[28]) r[j*ew + b] = 1'b0;
    end
    if (!st && ec != 2'd0)
      for (int b = bits; b < 512; b++) r[b] = 1'b0;
    return r;
  endfunction

  task automatic put(input logic [34:0] e, input logic [511:0] o, input logic [511:0] s);
    {enc, vlen, elem64, mask_en, zero_mode, dir_from_reg, mem_op, addr_lo, vvvv, wmask} = e;
    old_dst = o; src = s; in_valid = 1'b1;
  endtask

  task automatic chk_bit(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", rq, act, exp);
    end
  endtask

  task automatic chk_res(input string rq, input logic [511:0] ed, input logic eu,
                         input logic eg, input logic ew);
    checks++;
    if (new_dst !== ed || fault_ud !== eu || fault_gp !== eg || wr_en !== ew || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s act=%h ud%b gp%b we%b v%b exp=%h ud%b gp%b we%b", rq, new_dst,
               fault_ud, fault_gp, wr_en, out_valid, ed, eu, eg, ew);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] ed, a_exp;
    logic eu, eg, ew;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk_bit("R12 out_valid", out_valid, 1'b0);
    chk_bit("R12 wr_en", wr_en, 1'b0);
    chk_bit("R12 faults", fault_ud | fault_gp, 1'b0);
    chk_bit("R12 new_dst zero", |new_dst, 1'b0);
    chk_bit("R11 in_ready after reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      put(TBL[i], pat(2 * i + 1), pat(2 * i + 2));
      @(negedge clk);
      in_valid = 1'b0;
      ed = model(TBL[i], pat(2 * i + 1), pat(2 * i + 2), eu, eg, ew);
      chk_res($sformatf("R%0d vec%0d", TAG[i], i), ed, eu, eg, ew);
    end
    @(negedge clk);
    chk_bit("R11 valid drops when drained", out_valid, 1'b0);

    // R11 back-pressure: result held, no second accept
    out_ready = 1'b0;
    put(TBL[0], pat(40), pat(41));
    a_exp = model(TBL[0], pat(40), pat(41), eu, eg, ew);
    @(negedge clk);
    put(TBL[1], pat(42), pat(43));
    chk_bit("R11 in_ready low on stall", in_ready, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk_res("R11 held under stall", a_exp, eu, eg, ew);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ed = model(TBL[1], pat(42), pat(43), eu, eg, ew);
    chk_res("R11 second accepted after drain", ed, eu, eg, ew);

    // R12 reset while a stalled result is pending
    out_ready = 1'b0;
    put(TBL[3], pat(44), pat(45));
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_bit("R12 mid-stream valid", out_valid, 1'b0);
    chk_bit("R12 mid-stream data", |new_dst, 1'b0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule